// File: doc/BRIEF.md
# Receive DC-Correction Window Sequencer

This block sets the timing of a receiver's DC-offset correction phase and controls two general-purpose output pins. It runs on the reference clock, which is 26 MHz or 52 MHz. An optional pre-divide-by-two keeps the working tick equal to the reference divided by sixteen at either frequency. A correction sequence starts in one of two ways: on a rising edge of the receive-enable pin, or on a one-cycle start command strobe while receive-enable is high. The start loads two independent tick-based down-counters. The first counter sets how long the correction-active output stays high. The second sets how long the LNA-disable output stays high and how long the receive-side output override lasts.

The two pins normally carry a programmed two-bit pattern. Pin 0 can also be switched by a test selector. During the second window, a receive override pattern can replace the pins. While transmit-enable is high, a transmit override pattern can replace them, and this transmit pattern wins over the receive one. If receive-enable drops, both windows are cancelled at once.

Top module: `dcoc_seq`

## Requirements
- R1: With `cfg_auto_en`=1, a 0-to-1 change of `rx_en_i` sampled on a clock edge starts a sequence, and `dc_active_o` is high from the next cycle. With `cfg_auto_en`=0, the rising edge starts nothing.
- R2: A one-cycle `cfg_start_cmd` pulse while `rx_en_i`=1 starts a sequence. The same pulse while `rx_en_i`=0 has no effect.
- R3: With `cfg_half_en`=0, `dc_active_o` stays high for exactly 16·`cfg_t1` reference cycles after the starting edge.
- R4: With `cfg_mute_en`=1, `lna_off_o` stays high for exactly 16·`cfg_t2` reference cycles after the starting edge. With `cfg_mute_en`=0 it stays low.
- R5: With `cfg_rx_ovr_en`=1, `gp_o` equals `cfg_rx_pat` while the second window is open, and returns to the normal pattern when it closes. With `cfg_rx_ovr_en`=0, the window leaves `gp_o` untouched.
- R6: With `cfg_tx_ovr_en`=1, `gp_o` equals `cfg_tx_pat` from one cycle after `tx_en_i` rises until one cycle after it falls. With `cfg_tx_ovr_en`=0, `tx_en_i` has no effect on `gp_o`.
- R7: With `cfg_half_en`=1, one tick takes 32 reference cycles, so `dc_active_o` lasts 32·`cfg_t1` cycles.
- R8: A counter value of zero opens no window: the matching output stays low after a start.
- R9: A new start during an open window reloads both counters, so each window runs its full length again from the new start.
- R10: When the transmit override and the receive override are both active, `gp_o` carries `cfg_tx_pat`.
- R11: `rx_en_i`=0 closes both windows. From the next cycle `dc_active_o`=0, `lna_off_o`=0, and `gp_o` is back to the normal pattern.
- R12: With no override active, `gp_o[1]`=`cfg_norm_pat[1]`, and `gp_o[0]` follows `cfg_test_sel`: 00 gives `cfg_norm_pat[0]`, 01 gives `shift_data_i`, 10 gives `cal_msb_i`, 11 gives `dc_active_o`.
- R13: During reset `dc_active_o`=0, `lna_off_o`=0, and `gp_o` is the normal pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (26 or 52 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive-enable pin |
| tx_en_i | input | 1 | Transmit-enable pin |
| cfg_auto_en | input | 1 | Start on receive-enable rising edge |
| cfg_start_cmd | input | 1 | One-cycle start command strobe |
| cfg_half_en | input | 1 | Pre-divide the reference by two |
| cfg_mute_en | input | 1 | Drive LNA-disable during window 2 |
| cfg_rx_ovr_en | input | 1 | Receive override during window 2 |
| cfg_tx_ovr_en | input | 1 | Transmit override while transmitting |
| cfg_t1 | input | T1_W | Correction window length in ticks |
| cfg_t2 | input | T2_W | Mute/override window length in ticks |
| cfg_norm_pat | input | 2 | Normal pin pattern |
| cfg_rx_pat | input | 2 | Receive override pattern |
| cfg_tx_pat | input | 2 | Transmit override pattern |
| cfg_test_sel | input | 2 | Source select for pin 0 |
| shift_data_i | input | 1 | Serial shift data observation |
| cal_msb_i | input | 1 | Calibration counter MSB |
| dc_active_o | output | 1 | Correction window open |
| lna_off_o | output | 1 | LNA disable |
| gp_o | output | 2 | General-purpose pins |

## Verification
The correction window is started three ways: by an automatic rising edge, by a command strobe, and by a second start in the middle of a window. Each is checked at the last active cycle and the first idle cycle, which separates an off-by-one counter from a correct one and a reload from a continuation. Runs with the half-rate tick and with zero counter values show whether the divider and the empty-window rule are applied. Transmit, receive and overlapping override runs, plus a walk through all four test selections, show which pattern source wins in each case.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  localparam int unsigned TICK_DIV = 16;

  typedef enum logic [1:0] {
    TSEL_NORM  = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_CAL   = 2'b10,
    TSEL_CNT   = 2'b11
  } tsel_e;
endpackage

// File: rtl/dcoc_tick_gen.sv
module dcoc_tick_gen #(
  parameter int unsigned DIV = dcoc_pkg::TICK_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic half_en,
  output logic tick
);
  localparam int unsigned LW = $clog2(DIV);
  localparam int unsigned CW = LW + 1;
  localparam logic [CW-1:0] FULL_LAST = CW'(2 * DIV - 1);
  localparam logic [LW-1:0] BASE_LAST = LW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // half rate: every 2*DIV cycles; else every DIV cycles
  always_comb begin
    if (half_en) tick = (cnt_q == FULL_LAST);
    else         tick = (cnt_q[LW-1:0] == BASE_LAST);
  end
endmodule

// File: rtl/dcoc_win_timer.sv
module dcoc_win_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic         active
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (abort) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (start) begin
      cnt_d = load_val;
      act_d = |load_val;
    end else if (tick && act_q) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == ONE) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/dcoc_gp_mux.sv
module dcoc_gp_mux
  import dcoc_pkg::*;
#(
  parameter int unsigned PW = 2
) (
  input  tsel_e         tsel,
  input  logic [PW-1:0] norm_pat,
  input  logic          shift_data,
  input  logic          cal_msb,
  input  logic          cnt_sig,
  input  logic          rx_ovr,
  input  logic [PW-1:0] rx_pat,
  input  logic          tx_ovr,
  input  logic [PW-1:0] tx_pat,
  output logic [PW-1:0] gp
);
  logic [PW-1:0] base;

  always_comb begin
    base = norm_pat;
    unique case (tsel)
      TSEL_NORM:  base[0] = norm_pat[0];
      TSEL_SHIFT: base[0] = shift_data;
      TSEL_CAL:   base[0] = cal_msb;
      TSEL_CNT:   base[0] = cnt_sig;
      default:    base[0] = norm_pat[0];
    endcase
  end

  // transmit override outranks receive override
  always_comb begin
    if (tx_ovr)      gp = tx_pat;
    else if (rx_ovr) gp = rx_pat;
    else             gp = base;
  end
endmodule

// File: rtl/dcoc_seq.sv
module dcoc_seq
  import dcoc_pkg::*;
#(
  parameter int unsigned T1_W = 8,
  parameter int unsigned T2_W = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en_i,
  input  logic            tx_en_i,
  input  logic            cfg_auto_en,
  input  logic            cfg_start_cmd,
  input  logic            cfg_half_en,
  input  logic            cfg_mute_en,
  input  logic            cfg_rx_ovr_en,
  input  logic            cfg_tx_ovr_en,
  input  logic [T1_W-1:0] cfg_t1,
  input  logic [T2_W-1:0] cfg_t2,
  input  logic [1:0]      cfg_norm_pat,
  input  logic [1:0]      cfg_rx_pat,
  input  logic [1:0]      cfg_tx_pat,
  input  logic [1:0]      cfg_test_sel,
  input  logic            shift_data_i,
  input  logic            cal_msb_i,
  output logic            dc_active_o,
  output logic            lna_off_o,
  output logic [1:0]      gp_o
);
  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  // pin history
  logic rx_q, tx_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_en_i;
      tx_q <= tx_en_i;
    end
  end

  logic rx_rise, trig, abort, tick;
  logic win1, win2;

  assign rx_rise = rx_en_i & ~rx_q;
  assign trig    = (cfg_auto_en & rx_rise) | (cfg_start_cmd & rx_en_i);
  assign abort   = ~rx_en_i;

  dcoc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (trig),
    .half_en (cfg_half_en),
    .tick    (tick)
  );

  dcoc_win_timer #(.W(T1_W)) u_win1 (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (trig),
    .abort    (abort),
    .tick     (tick),
    .load_val (cfg_t1),
    .active   (win1)
  );

  dcoc_win_timer #(.W(T2_W)) u_win2 (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (trig),
    .abort    (abort),
    .tick     (tick),
    .load_val (cfg_t2),
    .active   (win2)
  );

  dcoc_gp_mux #(.PW(2)) u_mux (
    .tsel       (tsel_e'(cfg_test_sel)),
    .norm_pat   (cfg_norm_pat),
    .shift_data (shift_data_i),
    .cal_msb    (cal_msb_i),
    .cnt_sig    (win1),
    .rx_ovr     (win2 & cfg_rx_ovr_en),
    .rx_pat     (cfg_rx_pat),
    .tx_ovr     (tx_q & cfg_tx_ovr_en),
    .tx_pat     (cfg_tx_pat),
    .gp         (gp_o)
  );

  assign dc_active_o = win1;
  assign lna_off_o   = win2 & cfg_mute_en;
endmodule

// File: rtl/dcoc_seq_chk.sv
module dcoc_seq_chk #(
  parameter int unsigned T1_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_en_i,
  input logic            trig,
  input logic            tick,
  input logic            tx_q,
  input logic            cfg_mute_en,
  input logic            cfg_tx_ovr_en,
  input logic [1:0]      cfg_tx_pat,
  input logic [T1_W-1:0] cfg_t1,
  input logic            dc_active_o,
  input logic            lna_off_o,
  input logic [1:0]      gp_o
);
  a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_t1 != '0) |=> dc_active_o);

  a_r8_zero_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_t1 == '0) |=> !dc_active_o);

  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> (!dc_active_o && !lna_off_o));

  a_r4_mute_gated: assert property (@(posedge clk) disable iff (!rst_n)
    lna_off_o |-> cfg_mute_en);

  a_r3_close_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_active_o) |-> ($past(tick) || $past(!rx_en_i) || $past(trig)));

  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(trig) && $past(rx_en_i)) |-> $stable(dc_active_o));

  a_r10_tx_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q && cfg_tx_ovr_en) |-> (gp_o == cfg_tx_pat));
endmodule

bind dcoc_seq dcoc_seq_chk #(.T1_W(T1_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .rx_en_i       (rx_en_i),
  .trig          (trig),
  .tick          (tick),
  .tx_q          (tx_q),
  .cfg_mute_en   (cfg_mute_en),
  .cfg_tx_ovr_en (cfg_tx_ovr_en),
  .cfg_tx_pat    (cfg_tx_pat),
  .cfg_t1        (cfg_t1),
  .dc_active_o   (dc_active_o),
  .lna_off_o     (lna_off_o),
  .gp_o          (gp_o)
);

// File: tb/dcoc_seq_bench.sv
module dcoc_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_en, tx_en, auto_en, start_cmd, half_en, mute_en, rx_ovr, tx_ovr;
  logic [7:0] t1;
  logic [9:0] t2;
  logic [1:0] norm_pat, rx_pat, tx_pat, tsel;
  logic shift_d, cal_msb;
  logic dc_act, lna_off;
  logic [1:0] gp;

  dcoc_seq u_dcoc_seq (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .cfg_auto_en(auto_en), .cfg_start_cmd(start_cmd), .cfg_half_en(half_en),
    .cfg_mute_en(mute_en), .cfg_rx_ovr_en(rx_ovr), .cfg_tx_ovr_en(tx_ovr),
    .cfg_t1(t1), .cfg_t2(t2), .cfg_norm_pat(norm_pat), .cfg_rx_pat(rx_pat),
    .cfg_tx_pat(tx_pat), .cfg_test_sel(tsel), .shift_data_i(shift_d),
    .cal_msb_i(cal_msb), .dc_active_o(dc_act), .lna_off_o(lna_off), .gp_o(gp)
  );

  typedef struct {
    int         due;
    int         sel;
    logic [1:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: expected item after k more rising edges
  task automatic expect_at(int k, int sel, logic [1:0] v, string tag);
    item_t it;
    it.due = cyc + k; it.sel = sel; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_restart();
    rx_en = 1'b0; wait_n(2);
    rx_en = 1'b1;
  endtask

  // monitor: compare due items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          logic [1:0] act;
          case (q[i].sel)
            0:       act = {1'b0, dc_act};
            1:       act = {1'b0, lna_off};
            default: act = gp;
          endcase
          total++;
          if (act !== q[i].exp) begin
            bad++;
            $display("FAIL %s: sig=%0d actual=%0h expected=%0h at cycle %0d",
                     q[i].tag, q[i].sel, act, q[i].exp, cyc);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_en = 0; tx_en = 0; auto_en = 1; start_cmd = 0; half_en = 0;
    mute_en = 1; rx_ovr = 1; tx_ovr = 0; t1 = 8'd4; t2 = 10'd6;
    norm_pat = 2'b01; rx_pat = 2'b10; tx_pat = 2'b11; tsel = 2'b00;
    shift_d = 0; cal_msb = 0;
    wait_n(2);
    // R13 reset state
    expect_at(1, 0, 2'b00, "R13");
    expect_at(1, 1, 2'b00, "R13");
    expect_at(1, 2, 2'b01, "R13");
    wait_n(3);
    rst_n = 1;
    wait_n(5);

    // R1 R3 R4 R5: auto start, t1=4 -> 64 cycles, t2=6 -> 96 cycles
    rx_en = 1'b1;
    expect_at(1, 0, 2'b01, "R1");
    expect_at(64, 0, 2'b01, "R3");
    expect_at(65, 0, 2'b00, "R3");
    expect_at(1, 1, 2'b01, "R4");
    expect_at(96, 1, 2'b01, "R4");
    expect_at(97, 1, 2'b00, "R4");
    expect_at(50, 2, 2'b10, "R5");
    expect_at(97, 2, 2'b01, "R5");
    wait_n(110);

    // R1 negative: auto disabled
    auto_en = 0;
    rx_restart();
    expect_at(1, 0, 2'b00, "R1");
    expect_at(20, 0, 2'b00, "R1");
    wait_n(25);

    // R2: command while rx high
    start_cmd = 1;
    expect_at(1, 0, 2'b01, "R2");
    expect_at(64, 0, 2'b01, "R2");
    expect_at(65, 0, 2'b00, "R2");
    wait_n(1); start_cmd = 0;
    wait_n(70);
    // R2 negative: command while rx low
    rx_en = 0; wait_n(2);
    start_cmd = 1;
    expect_at(1, 0, 2'b00, "R2");
    expect_at(10, 0, 2'b00, "R2");
    wait_n(1); start_cmd = 0;
    wait_n(12);

    // R4 R5 negative: mute and rx override disabled
    auto_en = 1; mute_en = 0; rx_ovr = 0;
    rx_restart();
    expect_at(5, 0, 2'b01, "R1");
    expect_at(5, 1, 2'b00, "R4");
    expect_at(5, 2, 2'b01, "R5");
    wait_n(100);
    mute_en = 1; rx_ovr = 1;

    // R7: half rate, t1=2 -> 64 cycles
    half_en = 1; t1 = 8'd2;
    rx_restart();
    expect_at(64, 0, 2'b01, "R7");
    expect_at(65, 0, 2'b00, "R7");
    wait_n(200);
    half_en = 0;

    // R8: zero values open nothing
    t1 = 8'd0; t2 = 10'd0;
    rx_restart();
    expect_at(1, 0, 2'b00, "R8");
    expect_at(1, 1, 2'b00, "R8");
    expect_at(20, 1, 2'b00, "R8");
    expect_at(20, 2, 2'b01, "R8");
    wait_n(25);
    t1 = 8'd4; t2 = 10'd6;

    // R9: restart at cycle 40 of an open window
    rx_restart();
    wait_n(40);
    start_cmd = 1;
    expect_at(64, 0, 2'b01, "R9");
    expect_at(65, 0, 2'b00, "R9");
    expect_at(96, 1, 2'b01, "R9");
    expect_at(97, 1, 2'b00, "R9");
    wait_n(1); start_cmd = 0;
    wait_n(110);

    // R11: abort mid-window
    rx_restart();
    wait_n(10);
    rx_en = 0;
    expect_at(1, 0, 2'b00, "R11");
    expect_at(1, 1, 2'b00, "R11");
    expect_at(1, 2, 2'b01, "R11");
    wait_n(5);

    // R6: transmit override
    tx_ovr = 1; tx_en = 1;
    expect_at(1, 2, 2'b11, "R6");
    expect_at(10, 2, 2'b11, "R6");
    wait_n(12);
    tx_en = 0;
    expect_at(1, 2, 2'b01, "R6");
    wait_n(3);
    tx_ovr = 0; tx_en = 1;
    expect_at(2, 2, 2'b01, "R6");
    wait_n(4);
    tx_en = 0; wait_n(2);

    // R10: both overrides active
    tx_ovr = 1;
    rx_restart();
    wait_n(5);
    tx_en = 1;
    expect_at(1, 2, 2'b11, "R10");
    wait_n(3);
    tx_en = 0;
    expect_at(1, 2, 2'b10, "R10");
    wait_n(3);
    rx_en = 0; tx_ovr = 0; rx_ovr = 0;
    wait_n(3);

    // R12: test select walk, norm=10
    norm_pat = 2'b10; tsel = 2'b00;
    expect_at(1, 2, 2'b10, "R12");
    wait_n(2);
    tsel = 2'b01; shift_d = 1;
    expect_at(1, 2, 2'b11, "R12");
    wait_n(2);
    tsel = 2'b10; shift_d = 0; cal_msb = 0;
    expect_at(1, 2, 2'b10, "R12");
    wait_n(2);
    cal_msb = 1;
    expect_at(1, 2, 2'b11, "R12");
    wait_n(2);
    tsel = 2'b11;
    rx_en = 1'b1;
    expect_at(5, 2, 2'b11, "R12");
    expect_at(70, 2, 2'b10, "R12");
    wait_n(75);

    while (q.size() != 0) wait_n(1);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule